// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This block takes a 64-bit IEEE-754 double and turns it into a signed two's-complement integer. A width select picks the destination: a 32-bit word or a 64-bit long-word. The rounding direction is read at run time from the two low bits of a floating-point control/status register input. The same alignment and rounding path serves both widths. Only the final range check differs between them.

The converter is a single registered stage. An operand presented with `valid_in` high produces its result and flags on the next cycle, qualified by `valid_out`. A value that cannot be held in the chosen width is replaced by a fixed invalid code, which is the most positive integer of that width, and the invalid flag is raised. NaN and infinite operands are handled the same way. The flags describe one conversion only and are never accumulated.

Top module: `f2i_convert`

## Requirements
- R1: Result and flags appear on the clock edge after the one that samples `valid_in` high, with `valid_out` high for exactly that cycle. `valid_out` is low on the edge after a cycle with `valid_in` low, and `invalid` and `inexact` are both low whenever `valid_out` is low.
- R2: The rounding mode is taken from `fp_ctrl[1:0]` alone. Bits above bit 1 have no effect on any output.
- R3: Mode 0 rounds to the nearest integer. An operand exactly halfway between two integers goes to the even one (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R4: Mode 1 rounds toward zero (2.6 gives 2, -2.6 gives -2).
- R5: Mode 2 rounds toward plus infinity (2.4 gives 3, -2.6 gives -2).
- R6: Mode 3 rounds toward minus infinity (2.6 gives 2, -2.4 gives -3).
- R7: With `long_sel`=0 the destination is 32 bits wide, and `result[63:32]` is a copy of `result[31]`. With `long_sel`=1 the destination is 64 bits wide.
- R8: When the rounded value lies outside [-2^(W-1), 2^(W-1)-1] for the selected width W, `result` is 0x000000007FFFFFFF (word) or 0x7FFFFFFFFFFFFFFF (long-word), `invalid` is 1 and `inexact` is 0. The value -2^(W-1) itself converts normally.
- R9: An operand whose exponent field is all ones (NaN or infinity) always gives the invalid code of R8 with `invalid` high.
- R10: `inexact` is 1 exactly when the conversion is not invalid and the rounded integer differs from the operand. Integer-valued operands give `inexact`=0.
- R11: A zero or subnormal operand gives 0, except that mode 2 gives +1 for a positive subnormal and mode 3 gives -1 for a negative subnormal. `inexact` is 1 for every nonzero subnormal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | IEEE-754 double-precision operand |
| fp_ctrl | input | 32 | Floating-point control/status register; bits [1:0] give the rounding mode |
| long_sel | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| valid_out | output | 1 | Result and flags are valid |
| result | output | 64 | Signed integer result; in word mode it is sign-extended |
| invalid | output | 1 | Out-of-range, NaN or infinite operand |
| inexact | output | 1 | Rounded result differs from the operand |

## Verification
The block is a single stage, so a fault in the alignment shift or the rounding increment shows up at the ports on the very next edge. It appears as a result one unit off, or as a flipped `inexact`, and only for the operands whose discarded bits exercise that path. Halfway values in mode 0, tiny signed values in the directed modes, and operands near -2^31, 2^31 and 2^63 are the patterns that separate a wrong increment or a wrong range bound from a correct one. A register that latches the wrong cycle shows up as `valid_out` or the flags out of step with `valid_in`.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_TO_POS    = 2'd2,
      RM_TO_NEG    = 2'd3
   } rmode_t;
endpackage

// File: rtl/f2i_align.sv
// Splits the operand and places its magnitude on a fixed point grid:
// INT_W integer bits, one round bit and a sticky bit.
module f2i_align #(
   parameter int FP_W  = 64,
   parameter int EXP_W = 11,
   parameter int INT_W = 64
) (
   input  logic [FP_W-1:0]  operand,
   output logic             sign,
   output logic             special,
   output logic             huge,
   output logic [INT_W-1:0] mag,
   output logic             rnd,
   output logic             stk
);
   localparam int FRAC_W = FP_W - EXP_W - 1;
   localparam int MANT_W = FRAC_W + 1;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int FIX_W  = 2 * INT_W;
   localparam int SH_W   = $clog2(FIX_W);
   localparam int E_W    = EXP_W + 2;

   logic [EXP_W-1:0]      exp_f;
   logic [FRAC_W-1:0]     frac_f;
   logic [MANT_W-1:0]     mant;
   logic signed [E_W-1:0] e_unb;
   logic [SH_W-1:0]       sh;
   logic [FIX_W-1:0]      fixed_pt;
   logic                  tiny;

   assign sign    = operand[FP_W-1];
   assign exp_f   = operand[FP_W-2:FRAC_W];
   assign frac_f  = operand[FRAC_W-1:0];
   assign mant    = {(exp_f != '0), frac_f};
   assign special = &exp_f;
   assign e_unb   = $signed({2'b00, exp_f}) - E_W'(BIAS);
   assign huge    = e_unb > E_W'(INT_W - 1);
   assign tiny    = e_unb < -E_W'(1);
   assign sh      = SH_W'(e_unb + E_W'(INT_W - FRAC_W));
   assign fixed_pt = FIX_W'(mant) << sh;

   always_comb begin
      if (tiny) begin
         mag = '0;
         rnd = 1'b0;
         stk = |operand[FP_W-2:0];
      end else begin
         mag = fixed_pt[FIX_W-1:INT_W];
         rnd = fixed_pt[INT_W-1];
         stk = |fixed_pt[INT_W-2:0];
      end
   end
endmodule

// File: rtl/f2i_round.sv
// Applies the selected rounding direction to an unsigned magnitude.
module f2i_round #(
   parameter int INT_W = 64
) (
   input  f2i_pkg::rmode_t  mode,
   input  logic             sign,
   input  logic [INT_W-1:0] mag,
   input  logic             rnd,
   input  logic             stk,
   output logic [INT_W:0]   rmag,
   output logic             lost
);
   import f2i_pkg::*;
   logic inc;

   assign lost = rnd | stk;

   always_comb begin
      unique case (mode)
         RM_NEAR_EVEN: inc = rnd & (stk | mag[0]);
         RM_TO_ZERO:   inc = 1'b0;
         RM_TO_POS:    inc = ~sign & lost;
         RM_TO_NEG:    inc = sign & lost;
         default:      inc = 1'b0;
      endcase
   end

   assign rmag = {1'b0, mag} + (INT_W + 1)'(inc);
endmodule

// File: rtl/f2i_fit.sv
// Range test of a signed magnitude against a DST_W-bit destination.
module f2i_fit #(
   parameter int INT_W = 64,
   parameter int DST_W = 32
) (
   input  logic           sign,
   input  logic [INT_W:0] rmag,
   output logic           fits
);
   localparam logic [INT_W:0] NEG_LIM =
      {{(INT_W - DST_W + 1){1'b0}}, 1'b1, {(DST_W - 1){1'b0}}};

   assign fits = sign ? (rmag <= NEG_LIM) : (rmag < NEG_LIM);
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert #(
   parameter int FP_W   = 64,
   parameter int EXP_W  = 11,
   parameter int LONG_W = 64,
   parameter int WORD_W = 32,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [FP_W-1:0]   operand,
   input  logic [CTRL_W-1:0] fp_ctrl,
   input  logic              long_sel,
   output logic              valid_out,
   output logic [LONG_W-1:0] result,
   output logic              invalid,
   output logic              inexact
);
   import f2i_pkg::*;

   localparam int FRAC_W = FP_W - EXP_W - 1;
   localparam int N_DST  = 2;
   localparam logic [LONG_W-1:0] LONG_BAD = {1'b0, {(LONG_W - 1){1'b1}}};
   localparam logic [LONG_W-1:0] WORD_BAD =
      {{(LONG_W - WORD_W + 1){1'b0}}, {(WORD_W - 1){1'b1}}};

   if (LONG_W <= FRAC_W + 1) begin : g_chk_long
      $error("LONG_W must exceed the mantissa width");
   end
   if (WORD_W >= LONG_W || WORD_W < 2) begin : g_chk_word
      $error("WORD_W must lie in [2, LONG_W)");
   end
   if (CTRL_W < 3) begin : g_chk_ctrl
      $error("CTRL_W must be at least 3");
   end

   logic               sign, special, huge, rnd, stk, lost;
   logic [LONG_W-1:0]  mag;
   logic [LONG_W:0]    rmag;
   logic [N_DST-1:0]   fit_v;
   logic               sel_fit, bad;
   logic [LONG_W-1:0]  sval, conv_val;
   logic               ctrl_unused;
   rmode_t             mode;

   assign mode        = rmode_t'(fp_ctrl[1:0]);
   assign ctrl_unused = ^fp_ctrl[CTRL_W-1:2];

   f2i_align #(.FP_W(FP_W), .EXP_W(EXP_W), .INT_W(LONG_W)) u_align (
      .operand(operand), .sign(sign), .special(special), .huge(huge),
      .mag(mag), .rnd(rnd), .stk(stk)
   );

   f2i_round #(.INT_W(LONG_W)) u_round (
      .mode(mode), .sign(sign), .mag(mag), .rnd(rnd), .stk(stk),
      .rmag(rmag), .lost(lost)
   );

   // index 0: word destination, index 1: long-word destination
   for (genvar g = 0; g < N_DST; g++) begin : g_fit
      localparam int DW = (g == 0) ? WORD_W : LONG_W;
      f2i_fit #(.INT_W(LONG_W), .DST_W(DW)) u_fit (
         .sign(sign), .rmag(rmag), .fits(fit_v[g])
      );
   end

   assign sel_fit = long_sel ? fit_v[1] : fit_v[0];
   assign bad     = special | huge | ~sel_fit;
   assign sval    = sign ? -rmag[LONG_W-1:0] : rmag[LONG_W-1:0];

   always_comb begin
      if (bad)
         conv_val = long_sel ? LONG_BAD : WORD_BAD;
      else if (long_sel)
         conv_val = sval;
      else
         conv_val = {{(LONG_W - WORD_W){sval[WORD_W-1]}}, sval[WORD_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         result    <= '0;
         invalid   <= 1'b0;
         inexact   <= 1'b0;
      end else begin
         valid_out <= valid_in;
         invalid   <= valid_in & bad;
         inexact   <= valid_in & ~bad & lost;
         if (valid_in)
            result <= conv_val;
      end
   end
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
   parameter int EXP_W  = 11,
   parameter int LONG_W = 64,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_in,
   input logic [EXP_W-1:0]  op_exp,
   input logic              long_sel,
   input logic              valid_out,
   input logic [LONG_W-1:0] result,
   input logic              invalid,
   input logic              inexact
);
   localparam logic [LONG_W-1:0] LONG_BAD = {1'b0, {(LONG_W - 1){1'b1}}};
   localparam logic [LONG_W-1:0] WORD_BAD =
      {{(LONG_W - WORD_W + 1){1'b0}}, {(WORD_W - 1){1'b1}}};

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);
   // R1
   flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_out |-> (!invalid && !inexact));
   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(invalid && inexact));
   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> (result == ($past(long_sel) ? LONG_BAD : WORD_BAD)));
   // R7
   word_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && !$past(long_sel)) |->
      (result[LONG_W-1:WORD_W] == {(LONG_W - WORD_W){result[WORD_W-1]}}));
   // R9
   nan_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (&op_exp)) |=> invalid);
endmodule

bind f2i_convert f2i_convert_chk #(
   .EXP_W(EXP_W), .LONG_W(LONG_W), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
   .op_exp(operand[FP_W-2:FP_W-1-EXP_W]), .long_sel(long_sel),
   .valid_out(valid_out), .result(result), .invalid(invalid),
   .inexact(inexact)
);

// File: tb/sim_f2i_convert.sv
module sim_f2i_convert;
   localparam int CLK_P = 10;
   localparam logic [63:0] LONG_BAD = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] WORD_BAD = 64'h0000_0000_7FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [63:0] operand = '0;
   logic [31:0] fp_ctrl = '0;
   logic        long_sel = 1'b0;
   logic        valid_out, invalid, inexact;
   logic [63:0] result;

   int    total = 0;
   int    bad = 0;
   string cur_tag = "R3";

   logic [63:0] exp_res;
   bit          exp_v = 0, exp_inv = 0, exp_inx = 0;
   string       exp_tag = "";

   always #(CLK_P / 2) clk = ~clk;

   f2i_convert u0 (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .operand(operand),
      .fp_ctrl(fp_ctrl), .long_sel(long_sel), .valid_out(valid_out),
      .result(result), .invalid(invalid), .inexact(inexact)
   );

   function automatic void model(input logic [63:0] op, input int md,
                                 input bit ls, output logic [63:0] res,
                                 output bit inv, output bit inx);
      real x, fl, cl, r, lo, hi;
      longint v;
      if (op[62:52] == 11'h7FF) begin
         res = ls ? LONG_BAD : WORD_BAD; inv = 1; inx = 0;
         return;
      end
      x  = $bitstoreal(op);
      fl = $floor(x);
      cl = $ceil(x);
      case (md)
         0: begin
            if (x - fl < cl - x) r = fl;
            else if (x - fl > cl - x) r = cl;
            else r = (fl / 2.0 == $floor(fl / 2.0)) ? fl : cl;
         end
         1: r = (x > 0.0) ? fl : cl;
         2: r = cl;
         default: r = fl;
      endcase
      lo = ls ? -9223372036854775808.0 : -2147483648.0;
      hi = ls ?  9223372036854775808.0 :  2147483648.0;
      if (r < lo || r >= hi) begin
         res = ls ? LONG_BAD : WORD_BAD; inv = 1; inx = 0;
      end else begin
         v   = longint'(r);
         res = ls ? 64'(v) : {{32{v[31]}}, v[31:0]};
         inv = 0;
         inx = (r != x);
      end
   endfunction

   // reference model: expectations for the coming edge
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_v = 0; exp_inv = 0; exp_inx = 0;
      end else begin
         exp_v = valid_in;
         if (valid_in) begin
            model(operand, int'(fp_ctrl[1:0]), long_sel, exp_res, exp_inv, exp_inx);
            exp_tag = cur_tag;
         end else begin
            exp_inv = 0; exp_inx = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (valid_out !== exp_v) begin
            bad++;
            $display("FAIL R1 valid_out act=%0b exp=%0b", valid_out, exp_v);
         end
         total++;
         if (invalid !== exp_inv) begin
            bad++;
            $display("FAIL %s invalid act=%0b exp=%0b", exp_v ? exp_tag : "R1", invalid, exp_inv);
         end
         total++;
         if (inexact !== exp_inx) begin
            bad++;
            $display("FAIL R10 inexact act=%0b exp=%0b", inexact, exp_inx);
         end
         if (exp_v) begin
            total++;
            if (result !== exp_res) begin
               bad++;
               $display("FAIL %s result act=%h exp=%h", exp_tag, result, exp_res);
            end
         end
      end
   end

   // one operand in every mode and width; upper control bits are junk (R2)
   task automatic sweep(input logic [63:0] op, input string tag);
      for (int md = 0; md < 4; md++) begin
         for (int w = 0; w < 2; w++) begin
            valid_in = 1'b1;
            operand  = op;
            fp_ctrl  = {$urandom() % 32'h4000_0000, md[1:0]};
            long_sel = w[0];
            cur_tag  = (tag != "") ? tag :
                       (w == 0) ? "R7" : (md == 0) ? "R3" : (md == 1) ? "R4" :
                       (md == 2) ? "R5" : "R6";
            @(negedge clk);
            if ((md + w) % 3 == 0) begin
               valid_in = 1'b0;
               @(negedge clk);
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (valid_out !== 1'b0 || result !== 64'h0 || invalid !== 1'b0 || inexact !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset act=%0b/%h exp=0/0", valid_out, result);
      end
      rst_n = 1'b1;
      @(negedge clk);
      sweep($realtobits(2.5), "R3");
      sweep($realtobits(3.5), "R3");
      sweep($realtobits(-2.5), "R3");
      sweep($realtobits(0.5), "R3");
      sweep($realtobits(-1.5), "");
      sweep($realtobits(2.4), "");
      sweep($realtobits(2.6), "");
      sweep($realtobits(-2.6), "");
      sweep($realtobits(-2.4), "");
      sweep($realtobits(7.0), "R10");
      sweep($realtobits(4503599627370497.0), "R10");
      sweep($realtobits(2147483647.5), "R8");
      sweep($realtobits(-2147483648.0), "R8");
      sweep($realtobits(-2147483648.5), "R8");
      sweep($realtobits(4294967296.0), "R8");
      sweep($realtobits(9.3e18), "R8");
      sweep($realtobits(-9223372036854775808.0), "R8");
      sweep($realtobits(-9.3e18), "R8");
      sweep(64'h0000_0000_0000_0000, "R11");
      sweep(64'h8000_0000_0000_0000, "R11");
      sweep(64'h0000_0000_0000_0001, "R11");
      sweep(64'h8000_0000_0000_0001, "R11");
      sweep(64'h000F_FFFF_FFFF_FFFF, "R11");
      sweep(64'h7FF8_0000_0000_0000, "R9");
      sweep(64'h7FF0_0000_0000_0000, "R9");
      sweep(64'hFFF0_0000_0000_0000, "R9");
      // R2: same operand, only upper control bits vary
      for (int k = 0; k < 16; k++) begin
         valid_in = 1'b1;
         operand  = $realtobits(5.5);
         fp_ctrl  = {k[3:0], 26'h0, k[1:0], 2'd0};
         long_sel = k[0];
         cur_tag  = "R2";
         @(negedge clk);
      end
      // mixed operands around the integer range
      for (int k = 0; k < 500; k++) begin
         logic [10:0] e;
         e = 11'(960 + ($urandom() % 110));
         sweep({1'($urandom()), e, 20'($urandom()), 32'($urandom())}, "");
      end
      valid_in = 1'b0;
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule